// File: doc/BRIEF.md
# DMA Bus Tenure Limiter

This block sits beside a bus-master DMA engine and decides when the engine must hand the system bus back during one mastership period. Once the host acknowledges the DMA request, the block counts the data transfers made under that grant. It can also run a tenure timer, clocked by a 100 ns tick that is derived from the core clock. It raises a release request when the programmed transfer count is reached, when the timer runs out, or when the engine reports that no work is left. The earliest of these three conditions wins.

Transfers that move descriptors do not count toward either limit. While a descriptor access is in progress, neither limit can force a release; a timer expiry that falls inside a descriptor access takes effect at the first cycle after it. A burst-disable mode removes the count limit. The burst limit register can only be written while the engine is stopped or suspended. The release request stays high until the acknowledge drops. Then all counting state clears for the next grant.

Top module: `dma_tenure_limiter`

## Requirements
- R1: After reset `bus_release` is low and the burst limit holds 16, so with no later write a grant with a data strobe every cycle is released at the 16th counted strobe.
- R2: With the count limit active, `bus_release` rises at the same clock edge that counts the Nth data transfer, where N is the burst limit. A data transfer is an edge with `dma_ack`=1, `xfer_strobe`=1 and `desc_xfer`=0.
- R3: A burst limit of 0 behaves as a limit of 1.
- R4: Edges with `desc_xfer`=1 do not advance the transfer count. While `desc_xfer`=1, neither the count limit nor the timer can raise `bus_release`.
- R5: With `burst_off`=1 the transfer count never causes a release.
- R6: With `timer_on`=1 and `tenure_limit`=T>0, `bus_release` rises at the 20·T-th clock edge at which `dma_ack` is sampled high (T × 100 ns at the default 5 ns clock). The timer restarts at each new acknowledge.
- R7: With `timer_on`=1 and `tenure_limit`=0, `bus_release` rises at the edge that counts the first data transfer.
- R8: An edge that samples `dma_ack`=1 and `work_pending`=0 sets `bus_release`.
- R9: Once set, `bus_release` stays high while `dma_ack` stays high. It clears at the first edge that samples `dma_ack`=0. The count and the timer then restart from zero for the next grant.
- R10: A write strobe `burst_we` updates the burst limit only when `stop_or_suspend`=1. At other times it has no effect.
- R11: With `timer_on`=0 the tenure timer never causes a release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stop_or_suspend | input | 1 | Engine stopped or suspended; enables burst limit writes |
| burst_we | input | 1 | Burst limit write strobe |
| burst_wdata | input | 8 | Burst limit write value |
| burst_off | input | 1 | Disables the transfer-count limit |
| timer_on | input | 1 | Enables the tenure timer |
| tenure_limit | input | 16 | Maximum tenure in 100 ns units |
| dma_ack | input | 1 | Host DMA acknowledge; high during a mastership period |
| xfer_strobe | input | 1 | One bus transfer completes this cycle |
| desc_xfer | input | 1 | Current transfer is a descriptor access |
| work_pending | input | 1 | Engine still has transfers queued |
| bus_release | output | 1 | Request to give the bus back |

## Verification
A transfer count that is off by one, or that wrongly includes descriptor strobes, moves the rising edge of `bus_release` by exactly that many cycles inside the same grant. The bench therefore records the edge index of the release for every configuration and compares it with the exact expected index. A wrong prescaler wrap or tick count shifts a timer release by multiples of 20 cycles. A release latch that fails to clear or to hold shows on the first edge after `dma_ack` changes. A burst register that was corrupted by an ignored write only becomes visible at the next grant's release point.

// File: rtl/dtl_pkg.sv
package dtl_pkg;
    parameter int BURST_W = 8;
    parameter int TENURE_W = 16;
    parameter logic [BURST_W-1:0] BURST_RESET = 8'd16;

    typedef struct packed {
        logic [BURST_W-1:0] limit;
        logic               release_req;
    } top_state_t;
endpackage

// File: rtl/dtl_xfer_counter.sv
module dtl_xfer_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             count_en,
    input  logic [CNT_W-1:0] limit,
    input  logic             limit_off,
    output logic             limit_hit,
    output logic             first_seen
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic [CNT_W-1:0] eff_limit;

    always_comb begin
        st_d = st_q;
        if (!run) begin
            st_d.cnt = '0;
        end else if (count_en && st_q.cnt != CNT_MAX) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        eff_limit  = (limit == '0) ? {{(CNT_W-1){1'b0}}, 1'b1} : limit;
        limit_hit  = run && !limit_off && (st_d.cnt >= eff_limit);
        first_seen = run && (st_d.cnt != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4: a strobe that is not counted leaves the count unchanged
    assert_cnt_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !count_en) |=> (st_q.cnt == $past(st_q.cnt)));
    // R9: the count is zero after any edge without a grant
    assert_cnt_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (st_q.cnt == '0));
endmodule

// File: rtl/dtl_tenure_timer.sv
module dtl_tenure_timer #(
    parameter int TIMER_W  = 16,
    parameter int PRESCALE = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [TIMER_W-1:0] tenure,
    output logic               expired
);
    localparam int PS_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PS_W-1:0] PS_LAST = PS_W'(PRESCALE - 1);
    localparam logic [TIMER_W-1:0] UNITS_MAX = {TIMER_W{1'b1}};

    typedef struct packed {
        logic [PS_W-1:0]    presc;
        logic [TIMER_W-1:0] units;
    } tmr_state_t;

    tmr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!run) begin
            st_d.presc = '0;
            st_d.units = '0;
        end else if (st_q.presc == PS_LAST) begin
            st_d.presc = '0;
            if (st_q.units != UNITS_MAX) st_d.units = st_q.units + 1'b1;
        end else begin
            st_d.presc = st_q.presc + 1'b1;
        end
        expired = run && (tenure != '0) && (st_d.units >= tenure);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6: prescaler stays inside its period
    assert_presc_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.presc <= PS_LAST);
    // R9: timer restarts from zero after the grant ends
    assert_timer_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (st_q.units == '0 && st_q.presc == '0));
endmodule

// File: rtl/dma_tenure_limiter.sv
module dma_tenure_limiter
    import dtl_pkg::*;
#(
    parameter int CLK_PERIOD_PS = 5000,
    parameter int TICK_PS       = 100000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                stop_or_suspend,
    input  logic                burst_we,
    input  logic [BURST_W-1:0]  burst_wdata,
    input  logic                burst_off,
    input  logic                timer_on,
    input  logic [TENURE_W-1:0] tenure_limit,
    input  logic                dma_ack,
    input  logic                xfer_strobe,
    input  logic                desc_xfer,
    input  logic                work_pending,
    output logic                bus_release
);
    localparam int PRESCALE = (TICK_PS / CLK_PERIOD_PS > 0) ? TICK_PS / CLK_PERIOD_PS : 1;

    top_state_t st_d, st_q;
    logic data_xfer, burst_hit, first_xfer, tmr_expired, timer_hit, limit_hit;

    assign data_xfer = dma_ack && xfer_strobe && !desc_xfer;

    dtl_xfer_counter #(.CNT_W(BURST_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (dma_ack),
        .count_en   (data_xfer),
        .limit      (st_q.limit),
        .limit_off  (burst_off),
        .limit_hit  (burst_hit),
        .first_seen (first_xfer)
    );

    dtl_tenure_timer #(.TIMER_W(TENURE_W), .PRESCALE(PRESCALE)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (dma_ack),
        .tenure  (tenure_limit),
        .expired (tmr_expired)
    );

    always_comb begin
        st_d = st_q;
        if (burst_we && stop_or_suspend) st_d.limit = burst_wdata;
        timer_hit = timer_on && ((tenure_limit == '0) ? first_xfer : tmr_expired);
        limit_hit = (burst_hit || timer_hit) && !desc_xfer;
        st_d.release_req = dma_ack && (st_q.release_req || limit_hit || !work_pending);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.limit       <= BURST_RESET;
            st_q.release_req <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_release = st_q.release_req;

    // R9: release holds while the grant lasts
    assert_release_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_release && dma_ack) |=> bus_release);
    // R9: release drops after acknowledge is removed
    assert_release_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_ack |=> !bus_release);
    // R8: no pending work forces release
    assert_idle_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_ack && !work_pending) |=> bus_release);
    // R10: burst limit is frozen while running
    assert_limit_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_or_suspend |=> $stable(st_q.limit));
endmodule

// File: tb/dma_tenure_limiter_tb.sv
`timescale 1ns/1ps
module dma_tenure_limiter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stop_or_suspend = 1'b0, burst_we = 1'b0;
    logic [7:0]  burst_wdata = '0;
    logic        burst_off = 1'b0, timer_on = 1'b0;
    logic [15:0] tenure_limit = '0;
    logic        dma_ack = 1'b0, xfer_strobe = 1'b0, desc_xfer = 1'b0, work_pending = 1'b1;
    logic        bus_release;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dma_tenure_limiter u_dut (
        .clk(clk), .rst_n(rst_n), .stop_or_suspend(stop_or_suspend),
        .burst_we(burst_we), .burst_wdata(burst_wdata), .burst_off(burst_off),
        .timer_on(timer_on), .tenure_limit(tenure_limit), .dma_ack(dma_ack),
        .xfer_strobe(xfer_strobe), .desc_xfer(desc_xfer),
        .work_pending(work_pending), .bus_release(bus_release)
    );

    // fields: burst(8) burst_off(1) timer_on(1) tenure(16) desc_lead(8) expected_edge(8, 0 = none)
    localparam int NV = 10;
    localparam logic [41:0] VEC [NV] = '{
        {8'd4,   1'b0, 1'b0, 16'd0, 8'd0,  8'd4 },  // R2
        {8'd0,   1'b0, 1'b0, 16'd0, 8'd0,  8'd1 },  // R3
        {8'd10,  1'b0, 1'b0, 16'd0, 8'd3,  8'd13},  // R4
        {8'd3,   1'b1, 1'b0, 16'd0, 8'd0,  8'd0 },  // R5 R11
        {8'd200, 1'b0, 1'b1, 16'd2, 8'd0,  8'd40},  // R6
        {8'd200, 1'b0, 1'b1, 16'd0, 8'd0,  8'd1 },  // R7
        {8'd5,   1'b0, 1'b1, 16'd1, 8'd0,  8'd5 },  // R2 before timer
        {8'd50,  1'b0, 1'b1, 16'd1, 8'd0,  8'd20},  // R6 before count
        {8'd3,   1'b1, 1'b1, 16'd3, 8'd0,  8'd60},  // R5 R6
        {8'd200, 1'b0, 1'b1, 16'd1, 8'd25, 8'd26}   // R4 timer deferred
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_burst(input logic [7:0] v, input logic stop);
        @(negedge clk);
        stop_or_suspend = stop; burst_we = 1'b1; burst_wdata = v;
        @(negedge clk);
        burst_we = 1'b0; stop_or_suspend = 1'b0;
    endtask

    // run a grant; returns edge index at which release was seen (0 if none)
    task automatic run_grant(input int desc_lead, input int maxcyc, output int rel_edge);
        rel_edge = 0;
        for (int e = 1; e <= maxcyc && rel_edge == 0; e++) begin
            @(negedge clk);
            dma_ack = 1'b1; work_pending = 1'b1; xfer_strobe = 1'b1;
            desc_xfer = (e <= desc_lead);
            @(posedge clk); #1;
            if (bus_release) rel_edge = e;
        end
        @(negedge clk);
        xfer_strobe = 1'b0; desc_xfer = 1'b0;
    endtask

    task automatic end_grant();
        @(negedge clk);
        dma_ack = 1'b0; xfer_strobe = 1'b0;
        @(posedge clk); #1;
        check(bus_release == 1'b0, "R9", bus_release, 0);
    endtask

    initial begin
        int r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(bus_release == 1'b0, "R1", bus_release, 0);
        run_grant(0, 40, r);
        check(r == 16, "R1", r, 16);
        end_grant();

        for (int i = 0; i < NV; i++) begin
            logic [41:0] v;
            v = VEC[i];
            write_burst(v[41:34], 1'b1);
            burst_off = v[33]; timer_on = v[32]; tenure_limit = v[31:16];
            run_grant(int'(v[15:8]), 80, r);
            check(r == int'(v[7:0]), "R2-table vector", r, int'(v[7:0]));
            end_grant();
        end
        burst_off = 1'b0; timer_on = 1'b0; tenure_limit = '0;

        // R10: write without stop is ignored
        write_burst(8'd4, 1'b1);
        write_burst(8'd2, 1'b0);
        run_grant(0, 40, r);
        check(r == 4, "R10", r, 4);
        end_grant();

        // R9: count restarts after a partial grant
        run_grant(0, 2, r);
        check(r == 0, "R9", r, 0);
        end_grant();
        run_grant(0, 40, r);
        check(r == 4, "R9", r, 4);

        // R9: hold while ack stays high, even with pending work and no strobes
        repeat (5) begin
            @(negedge clk); work_pending = 1'b1;
            @(posedge clk); #1;
            check(bus_release == 1'b1, "R9", bus_release, 1);
        end
        end_grant();

        // R8: pending drops early in a grant
        run_grant(0, 1, r);
        check(r == 0, "R8", r, 0);
        @(negedge clk); work_pending = 1'b0;
        @(posedge clk); #1;
        check(bus_release == 1'b1, "R8", bus_release, 1);
        end_grant();
        work_pending = 1'b1;

        // R11: timer off with tenure programmed, no strobes: no release
        timer_on = 1'b0; tenure_limit = 16'd1;
        r = 0;
        for (int e = 1; e <= 60; e++) begin
            @(negedge clk); dma_ack = 1'b1;
            @(posedge clk); #1;
            if (bus_release && r == 0) r = e;
        end
        check(r == 0, "R11", r, 0);
        end_grant();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; failures++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule